// File: doc/BRIEF.md
# Non-Restoring Unsigned Divider

A multi-cycle integer divider for two unsigned `WIDTH`-bit operands, producing a `WIDTH`-bit quotient and a `WIDTH`-bit remainder. The datapath has three registers:

- A partial remainder one bit wider than the operands, whose top bit serves as a sign.
- A quotient register that starts out holding the dividend.
- A divisor register, also widened by one leading zero bit.

One iteration runs per clock. The partial remainder and the quotient shift left as one unit. The divisor is then subtracted from the partial remainder if it was non-negative, or added to it if it was negative. The new quotient bit is the inverse of the resulting sign. No restore step is ever taken inside the loop. Once all `WIDTH` iterations are finished, a single extra cycle adds the divisor back if the partial remainder ended negative.

A caller raises `start_i` for one cycle while the block is idle. The operands are captured on that edge and may change afterwards. `busy_o` stays high while the iterations and the correction run. `done_o` then pulses for one cycle, and the results remain on the outputs until the next accepted start. A zero divisor skips the iterations entirely and is reported through `div_zero_o`.

Top module: `nr_divider`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A `start_i` sampled high while `busy_o` is low captures both operands on that edge; with a non-zero divisor `busy_o` is high in the following cycle.
- R3: For a non-zero divisor, in the `done_o` cycle `quotient_o` equals floor(dividend / divisor) and `remainder_o` equals dividend mod divisor, so quotient*divisor + remainder = dividend and remainder < divisor.
- R4: For a non-zero divisor, `busy_o` is high for exactly `WIDTH`+1 consecutive cycles (`WIDTH` iterations plus one correction), and `done_o` is high in the cycle right after, i.e. `WIDTH`+2 cycles after the accepting edge.
- R5: `done_o` is high for a single cycle per accepted start, and `busy_o` is low in that cycle.
- R6: A zero divisor gives `done_o` and `div_zero_o` high in the cycle after the accepting edge, `quotient_o` all ones, `remainder_o` equal to the dividend, and `busy_o` never rising.
- R7: For a non-zero divisor, `div_zero_o` is low in the `done_o` cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored: the run in progress completes with the results of its own operands, and no second `done_o` follows.
- R9: While idle and without a new start, `quotient_o` and `remainder_o` hold their last values.
- R10: Changing `dividend_i` or `divisor_i` after the accepting edge has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Iterations or correction in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| div_zero_o | output | 1 | Last accepted division had a zero divisor |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
The assertions check the following on every cycle, for whatever operands happen to arrive:

- The divide identity and the remainder bound hold at `done_o`, against operands the checker captured on the accepting edge.
- The run length is `WIDTH`+1 busy cycles, counted by the checker.
- `done_o` lasts one cycle and never overlaps `busy_o`.
- A zero divisor takes the short path.
- Outputs hold while idle.

Only the bench's scenarios can show the other behaviours:

- Exact quotient and remainder values at the extremes: all-ones operands, a zero dividend, a divisor larger than the dividend, and equal operands.
- That a start pulsed mid-run is dropped.
- That operands scrambled after the accepting edge leave the result untouched.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } div_state_e;

  typedef struct packed {
    logic load;       // normal operand capture
    logic load_zero;  // zero-divisor shortcut
    logic step;       // one shift/add-sub iteration
    logic fix;        // final remainder correction
  } dp_ctrl_t;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH:0] a_i,
  input  logic           q_msb_i,
  input  logic [WIDTH:0] m_i,
  output logic [WIDTH:0] a_o,
  output logic           q_bit_o
);
  logic [WIDTH:0] a_sh;

  always_comb begin
    a_sh = {a_i[WIDTH-1:0], q_msb_i};
    // sign of A before the shift picks the operation
    if (a_i[WIDTH]) a_o = a_sh + m_i;
    else            a_o = a_sh - m_i;
    q_bit_o = ~a_o[WIDTH];
  end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     divisor_zero_i,
  output dp_ctrl_t ctrl_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     div_zero_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, dz_q, dz_d;
  logic             accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    ctrl_o.load      = accept && !divisor_zero_i;
    ctrl_o.load_zero = accept && divisor_zero_i;
    ctrl_o.step      = (state_q == ST_RUN);
    ctrl_o.fix       = (state_q == ST_FIX);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dz_d    = dz_q;
    if (accept) dz_d = divisor_zero_i;
    unique case (state_q)
      ST_IDLE: begin
        if (ctrl_o.load) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_ITER) state_d = ST_FIX;
      end
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= ctrl_o.load_zero || ctrl_o.fix;
      dz_q    <= dz_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
endmodule

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath
  import nrdiv_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dp_ctrl_t         ctrl_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             divisor_zero_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned AW = WIDTH + 1;

  logic [AW-1:0]    a_q, m_q, a_step;
  logic [WIDTH-1:0] q_q;
  logic             q_bit;

  assign divisor_zero_o = (divisor_i == '0);

  nrdiv_step #(.WIDTH(WIDTH)) u_step (
    .a_i     (a_q),
    .q_msb_i (q_q[WIDTH-1]),
    .m_i     (m_q),
    .a_o     (a_step),
    .q_bit_o (q_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      q_q <= '0;
      m_q <= '0;
    end else if (ctrl_i.load) begin
      a_q <= '0;
      q_q <= dividend_i;
      m_q <= {1'b0, divisor_i};
    end else if (ctrl_i.load_zero) begin
      a_q <= {1'b0, dividend_i};
      q_q <= '1;
      m_q <= '0;
    end else if (ctrl_i.step) begin
      a_q <= a_step;
      q_q <= {q_q[WIDTH-2:0], q_bit};
    end else if (ctrl_i.fix && a_q[AW-1]) begin
      a_q <= a_q + m_q;
    end
  end

  assign quotient_o  = q_q;
  assign remainder_o = a_q[WIDTH-1:0];
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nrdiv_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  dp_ctrl_t ctrl;
  logic     divisor_zero;

  nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .divisor_zero_i (divisor_zero),
    .ctrl_o         (ctrl),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .div_zero_o     (div_zero_o)
  );

  nrdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_i         (ctrl),
    .dividend_i     (dividend_i),
    .divisor_i      (divisor_i),
    .divisor_zero_o (divisor_zero),
    .quotient_o     (quotient_o),
    .remainder_o    (remainder_o)
  );
endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             div_zero_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned CW = $clog2(WIDTH + 3);

  logic [WIDTH-1:0]   cap_n, cap_d;
  logic [CW-1:0]      busy_cnt;
  logic [2*WIDTH-1:0] recon;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_n    <= '0;
      cap_d    <= '0;
      busy_cnt <= '0;
    end else begin
      if (start_i && !busy_o) begin
        cap_n <= dividend_i;
        cap_d <= divisor_i;
      end
      if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else        busy_cnt <= '0;
    end
  end

  assign recon = (2*WIDTH)'(quotient_o) * (2*WIDTH)'(cap_d) + (2*WIDTH)'(remainder_o);

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i != '0) |=> busy_o); // R2
  AST_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_d != '0) |-> recon == (2*WIDTH)'(cap_n)); // R3
  AST_REM_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_d != '0) |-> remainder_o < cap_d); // R3
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> busy_cnt == CW'(WIDTH + 1)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> done_o && div_zero_o && !busy_o); // R6
  AST_ZERO_VALUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> quotient_o == '1 && remainder_o == cap_n); // R6
  AST_NZ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_d != '0) |-> !div_zero_o); // R7
  AST_RUN_FINISHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(quotient_o) && $stable(remainder_o)); // R9
endmodule

bind nr_divider nrdiv_checker #(.WIDTH(WIDTH)) u_nrdiv_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .div_zero_o  (div_zero_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/tb_nr_divider.sv
`timescale 1ns/1ps
module tb_nr_divider;
  localparam int unsigned W = 16;
  localparam int NVEC = 12;
  // {dividend, divisor}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd100,   16'd7},     {16'd65535, 16'd1},    {16'd65535, 16'd65535},
    {16'd0,     16'd5},     {16'd5,     16'd9},    {16'd65534, 16'd65535},
    {16'd32768, 16'd3},     {16'd1234,  16'd1234}, {16'd40000, 16'd256},
    {16'd65535, 16'd2},     {16'd1,     16'd1},    {16'd12345, 16'd17}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic         busy, done, dz;
  logic [W-1:0] quo, rem;
  int           checks = 0, failures = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  nr_divider #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .div_zero_o(dz),
    .quotient_o(quo), .remainder_o(rem)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // run one division; optional mid-run start with other operands
  task automatic run_div(input logic [W-1:0] n, input logic [W-1:0] d,
                         input bit poke, output int lat);
    int cyc;
    logic [W-1:0] eq, er;
    @(negedge clk);
    dvd = n; dvs = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dvd = ~n; dvs = d ^ 16'h5a5a; // R10 scramble after capture
    cyc = 1;
    if (d != 0) chk(busy, "R2", "busy after accept", busy, 1);
    while (!done && cyc < 100) begin
      if (poke && cyc == 3) begin
        start = 1'b1; dvd = 16'd9; dvs = 16'd2; // R8 ignored
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    lat = cyc;
    chk(!busy, "R5", "busy low at done", busy, 0);
    if (d == 0) begin
      chk(quo == '1, "R6", "quotient", quo, 16'hffff);
      chk(rem == n, "R6", "remainder", rem, n);
      chk(dz, "R6", "div_zero flag", dz, 1);
      chk(lat == 1, "R6", "latency", lat, 1);
    end else begin
      eq = n / d; er = n % d;
      chk(quo == eq, "R3", "quotient", quo, eq);
      chk(rem == er, "R3", "remainder", rem, er);
      chk(!dz, "R7", "div_zero flag", dz, 0);
      chk(lat == W + 2, "R4", "latency", lat, W + 2);
    end
    @(negedge clk);
    chk(!done, "R5", "done single cycle", done, 0);
  endtask

  initial begin
    int lat;
    logic [W-1:0] hq, hr;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dz && quo == 0 && rem == 0, "R1", "outputs in reset",
        {busy, done, dz}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && quo == 0 && rem == 0, "R1", "outputs after release",
        quo, 0);

    for (int i = 0; i < NVEC; i++) run_div(VEC[i][31:16], VEC[i][15:0], 1'b0, lat);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] rn, rd;
      rn = W'($urandom);
      rd = W'($urandom) >> ($urandom % 16);
      if (rd == 0) rd = 16'd3;
      run_div(rn, rd, 1'b0, lat);
    end

    run_div(16'd777, 16'd0, 1'b0, lat);   // R6 zero divisor
    run_div(16'd0, 16'd0, 1'b0, lat);     // R6 zero both
    run_div(16'd50000, 16'd123, 1'b1, lat); // R8 start while busy
    chk(!busy, "R8", "no second run", busy, 0);

    // R9 hold
    hq = quo; hr = rem;
    dvd = 16'd1; dvs = 16'd1;
    repeat (5) @(negedge clk);
    chk(quo == hq, "R9", "quotient held", quo, hq);
    chk(rem == hr, "R9", "remainder held", rem, hr);
    chk(!done, "R9", "no spurious done", done, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule